// File: doc/BRIEF.md
# Per-Port Statistics Counter Bank

This block keeps the event statistics of one Ethernet port: thirty-six counters, each driven by its own one-cycle increment strobe from the frame classification logic. Software does not see the counters directly. It reaches them through a two-word register window made of a control/status word and a read-only data word.

To fetch a counter, software writes the control word with a counter index and the request bit set. The request bit stays set while the block performs an internal fetch of fixed length. When the bit drops, the data word holds the counter value, and that counter has been cleared. Every read is therefore a read-and-clear, and software adds the returned deltas into its own wider totals.

The index map is sparse. The thirty-two per-direction event counters sit at indices 0x00 to 0x1F. The four aggregate counters sit at 0x80 to 0x83: receive total, transmit total, receive discards, transmit discards. Any other index reads as zero.

Top module: `mib_stats_port`

## Requirements
- R1: After reset, the control word reads all zeros, the data word reads zero, and every counter holds zero.
- R2: In each clock cycle in which its strobe `cnt_inc[s]` is high, counter slot s grows by one. Slots 0 to 31 are indices 0x00 to 0x1F, and slots 32 to 35 are indices 0x80 to 0x83.
- R3: A write with `reg_sel`=0 and bit 31 (request) set starts a fetch of the counter named in bits [7:0]. Bit 31 of the control word then reads 1 for exactly FETCH_LAT cycles (default 2, at least 2) and returns to 0 by itself. Bits [7:0] read back the index, and all other bits read 0.
- R4: When the request bit drops, the data word (`reg_sel`=1) holds the counter value as it stood before the completing edge. That value stays unchanged until the next fetch completes.
- R5: The fetched counter is reset to zero on the completing edge, so a second fetch returns only the events counted since the first.
- R6: An increment of the fetched counter in the same cycle as its completing edge is kept. It is not part of the returned value, and the counter restarts at 1.
- R7: A counter that holds all ones (CNT_W bits) stays at all ones on further increments and does not wrap.
- R8: Indices 0x80, 0x81, 0x82 and 0x83 return slots 32, 33, 34 and 35. Indices 0x00 to 0x1F return slots 0 to 31.
- R9: A fetch of any index outside both valid ranges completes with the normal timing and returns zero, and no counter is cleared.
- R10: Control-word writes that arrive while a request is pending are ignored. Neither the index nor the fetched slot changes.
- R11: A fetch clears only the selected counter. All other counters keep their values.
- R12: Writes with `reg_sel`=1 have no effect. The data word is read-only, and no fetch starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Word select: 0 = control/status, 1 = data |
| reg_wdata | input | 32 | Write data (control word: bit 31 request, bits [7:0] index) |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| cnt_inc | input | 36 | One increment strobe per counter slot |

## Verification
A control write sampled on edge E0 makes the request bit visible right after E0. The bit stays high through FETCH_LAT edges, and the data word and the counter clear are updated on edge E0+FETCH_LAT. The bench drives and samples on falling edges: it checks the request bit once after each of the FETCH_LAT rising edges and reads the data word only after the edge that drops the bit. For the collision case of R6, the strobe is placed in the falling-edge slot just before the completing edge. Increment strobes count on the rising edge that follows their assertion, so a reference count is compared only after that edge has passed.

// File: rtl/mib_stats_pkg.sv
package mib_stats_pkg;

    // Counter population and sparse index layout
    localparam int LO_COUNT  = 32;           // event counters at 0x00..0x1F
    localparam int HI_COUNT  = 4;            // aggregate counters at HI_BASE..
    localparam int HI_BASE   = 'h80;
    localparam int NUM_SLOTS = LO_COUNT + HI_COUNT;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    // Register window layout
    localparam int REG_W   = 32;
    localparam int IDX_W   = 8;
    localparam int REQ_BIT = 31;

    typedef enum logic [0:0] {
        FS_IDLE  = 1'b0,
        FS_FETCH = 1'b1
    } fetch_state_t;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } slot_sel_t;

    typedef struct packed {
        fetch_state_t     st;
        logic [IDX_W-1:0] idx;
    } ctl_state_t;

    // Sparse index to dense slot translation
    function automatic slot_sel_t map_index(input logic [IDX_W-1:0] idx);
        slot_sel_t r;
        r.hit  = 1'b0;
        r.slot = '0;
        if (int'(idx) < LO_COUNT) begin
            r.hit  = 1'b1;
            r.slot = SLOT_W'(idx);
        end else if (int'(idx) >= HI_BASE && int'(idx) < HI_BASE + HI_COUNT) begin
            r.hit  = 1'b1;
            r.slot = SLOT_W'(LO_COUNT + int'(idx) - HI_BASE);
        end
        return r;
    endfunction

    // Control word as seen on the read side
    function automatic logic [REG_W-1:0] pack_ctl(input ctl_state_t c);
        logic [REG_W-1:0] w;
        w              = '0;
        w[REQ_BIT]     = (c.st == FS_FETCH);
        w[IDX_W-1:0]   = c.idx;
        return w;
    endfunction

endpackage

// File: rtl/mib_sat_cnt.sv
module mib_sat_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] nxt;

    always_comb begin
        if (clr) begin
            nxt = inc ? ONE : '0;
        end else if (inc && (value != ALL_ONES)) begin
            nxt = value + ONE;
        end else begin
            nxt = value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else begin
            value <= nxt;
        end
    end
endmodule

// File: rtl/mib_counter_bank.sv
module mib_counter_bank
    import mib_stats_pkg::*;
#(
    parameter int NUM   = NUM_SLOTS,
    parameter int CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM-1:0]            inc,
    input  logic                      clr_en,
    input  logic [SLOT_W-1:0]         clr_slot,
    output logic [NUM-1:0][CNT_W-1:0] cnt
);
    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        logic clr_here;
        assign clr_here = clr_en && (clr_slot == SLOT_W'(g));

        mib_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (inc[g]),
            .clr   (clr_here),
            .value (cnt[g])
        );
    end
endmodule

// File: rtl/mib_fetch_ctl.sv
module mib_fetch_ctl
    import mib_stats_pkg::*;
#(
    parameter int FETCH_LAT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_word,
    output ctl_state_t       ctl,
    output logic             done
);
    localparam int WC_W = $clog2(FETCH_LAT) + 1;
    localparam logic [WC_W-1:0] LAST = WC_W'(FETCH_LAT - 1);

    logic [WC_W-1:0] wcnt;

    assign done = (ctl.st == FS_FETCH) && (wcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.st  <= FS_IDLE;
            ctl.idx <= '0;
            wcnt    <= '0;
        end else begin
            unique case (ctl.st)
                FS_IDLE: begin
                    if (wr_en) begin
                        ctl.idx <= wr_word[IDX_W-1:0];
                        wcnt    <= '0;
                        if (wr_word[REQ_BIT]) begin
                            ctl.st <= FS_FETCH;
                        end
                    end
                end
                FS_FETCH: begin
                    if (done) begin
                        ctl.st <= FS_IDLE;
                    end else begin
                        wcnt <= wcnt + WC_W'(1);
                    end
                end
                default: ctl.st <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mib_stats_port.sv
module mib_stats_port
    import mib_stats_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int FETCH_LAT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic                 reg_sel,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [NUM_SLOTS-1:0] cnt_inc
);
    ctl_state_t                       ctl;
    logic                             done;
    slot_sel_t                        sel;
    logic [NUM_SLOTS-1:0][CNT_W-1:0]  cnt_arr;
    logic [REG_W-1:0]                 data_q;
    logic [REG_W-1:0]                 ctl_word;
    logic                             ctl_wr;

    assign ctl_wr   = reg_we && !reg_sel;
    assign sel      = map_index(ctl.idx);
    assign ctl_word = pack_ctl(ctl);

    mib_fetch_ctl #(.FETCH_LAT(FETCH_LAT)) u_fetch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl_wr),
        .wr_word (reg_wdata),
        .ctl     (ctl),
        .done    (done)
    );

    mib_counter_bank #(.NUM(NUM_SLOTS), .CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .inc      (cnt_inc),
        .clr_en   (done && sel.hit),
        .clr_slot (sel.slot),
        .cnt      (cnt_arr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (done) begin
            data_q <= sel.hit ? REG_W'(cnt_arr[sel.slot]) : '0;
        end
    end

    assign reg_rdata = reg_sel ? data_q : ctl_word;
endmodule

// File: rtl/mib_stats_chk.sv
module mib_stats_chk
    import mib_stats_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int FETCH_LAT = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] ctl_word,
    input logic [REG_W-1:0] data_q,
    input logic [CNT_W-1:0] cnt0
);
    logic        req;
    logic [15:0] run;

    assign req = ctl_word[REQ_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else if (req) begin
            run <= run + 16'd1;
        end else begin
            run <= '0;
        end
    end

    AST_REQ_MAX_LEN: assert property (@(posedge clk) disable iff (rst)
        req |-> (int'(run) < FETCH_LAT)); // R3
    AST_REQ_EXACT_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> (int'($past(run)) == FETCH_LAT - 1)); // R3
    AST_IDX_HELD: assert property (@(posedge clk) disable iff (rst)
        (req && $past(req)) |-> $stable(ctl_word[IDX_W-1:0])); // R10
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !$fell(req) |-> $stable(data_q)); // R4
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($fell(req) && !map_index(ctl_word[IDX_W-1:0]).hit) |-> (data_q == '0)); // R9
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (($past(cnt0) == {CNT_W{1'b1}}) && !$fell(req)) |-> (cnt0 == {CNT_W{1'b1}})); // R7
endmodule

bind mib_stats_port mib_stats_chk #(.CNT_W(CNT_W), .FETCH_LAT(FETCH_LAT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctl_word (ctl_word),
    .data_q   (data_q),
    .cnt0     (cnt_arr[0])
);

// File: tb/tb_mib_stats_port.sv
module tb_mib_stats_port;
    localparam int CW   = 8;
    localparam int LAT  = 2;
    localparam int NS   = 36;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic          reg_sel = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NS-1:0] cnt_inc = '0;

    int errors = 0;
    int checks = 0;
    int expv [NS];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mib_stats_port #(.CNT_W(CW), .FETCH_LAT(LAT)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_inc(cnt_inc)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int slot_of(input int idx);
        if (idx < 32) return idx;
        return 32 + idx - 'h80;
    endfunction

    task automatic rd(input bit sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic wr(input bit sel, input logic [31:0] w);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = w;
        @(negedge clk);
        reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input int slot, input int n);
        for (int i = 0; i < n; i++) begin
            cnt_inc[slot] = 1'b1;
            @(negedge clk);
            cnt_inc[slot] = 1'b0;
        end
        expv[slot] = (expv[slot] + n > MAXV) ? MAXV : expv[slot] + n;
    endtask

    // Full fetch with request-bit timing checks (R3)
    task automatic fetch(input int idx, output int val);
        logic [31:0] v;
        wr(1'b0, 32'h8000_0000 | idx);
        for (int k = 0; k < LAT; k++) begin
            rd(1'b0, v);
            chk(v[31] == 1'b1, "R3 request pending", v[31], 1);
            @(negedge clk);
        end
        rd(1'b0, v);
        chk(v == 32'(idx), "R3 request cleared, index kept", v, idx);
        rd(1'b1, v);
        val = int'(v);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        int r;
        rd(1'b0, v); chk(v == 0, "R1 control after reset", v, 0);
        rd(1'b1, v); chk(v == 0, "R1 data after reset", v, 0);
        fetch('h83, r); chk(r == 0, "R1 counter after reset", r, 0);
    endtask

    task automatic t_basic();
        int r;
        pulse(5, 7);
        fetch('h05, r); chk(r == 7, "R2 count of strobes", r, 7);
        expv[5] = 0;
        fetch('h05, r); chk(r == 0, "R5 cleared on read", r, 0);
        pulse(5, 3);
        fetch('h05, r); chk(r == 3, "R5 delta since last read", r, 3);
        expv[5] = 0;
    endtask

    task automatic t_hold();
        logic [31:0] v;
        int r;
        pulse(12, 4);
        fetch('h0C, r); chk(r == 4, "R4 fetched value", r, 4);
        expv[12] = 0;
        pulse(12, 5);
        rd(1'b1, v); chk(v == 4, "R4 data word held", v, 4);
    endtask

    task automatic t_sparse();
        int r;
        for (int i = 0; i < 4; i++) pulse(32 + i, i + 1);
        pulse(31, 9);
        for (int i = 0; i < 4; i++) begin
            fetch('h80 + i, r);
            chk(r == i + 1, "R8 high index maps to slot 32+", r, i + 1);
            expv[32 + i] = 0;
        end
        fetch('h1F, r); chk(r == 9, "R8 index 0x1F", r, 9);
        expv[31] = 0;
    endtask

    task automatic t_indep();
        int r;
        pulse(3, 4);
        pulse(4, 2);
        fetch('h04, r); chk(r == 2, "R11 selected slot", r, 2);
        expv[4] = 0;
        fetch('h03, r); chk(r == expv[3], "R11 neighbour untouched", r, expv[3]);
        expv[3] = 0;
    endtask

    task automatic t_invalid();
        int r;
        int bad [4] = '{'h20, 'h7F, 'h84, 'hFF};
        pulse(0, 3);
        for (int i = 0; i < 4; i++) begin
            fetch(bad[i], r); chk(r == 0, "R9 unmapped index reads zero", r, 0);
        end
        fetch('h00, r); chk(r == 3, "R9 no counter cleared", r, 3);
        expv[0] = 0;
    endtask

    task automatic t_collide();
        logic [31:0] v;
        int r;
        pulse(10, 5);
        wr(1'b0, 32'h8000_000A);
        for (int k = 0; k < LAT - 1; k++) @(negedge clk);
        cnt_inc[10] = 1'b1;
        @(negedge clk);
        cnt_inc[10] = 1'b0;
        rd(1'b0, v); chk(v[31] == 1'b0, "R6 fetch completed", v[31], 0);
        rd(1'b1, v); chk(v == 5, "R6 colliding strobe not in value", v, 5);
        fetch('h0A, r); chk(r == 1, "R6 counter restarts at one", r, 1);
        expv[10] = 0;
    endtask

    task automatic t_busy();
        logic [31:0] v;
        int r;
        pulse(1, 2);
        pulse(2, 6);
        wr(1'b0, 32'h8000_0001);
        wr(1'b0, 32'h8000_0002);
        for (int k = 0; k < 10; k++) begin
            rd(1'b0, v);
            if (!v[31]) break;
            @(negedge clk);
        end
        chk(v == 32'h1, "R10 index unchanged by pending write", v, 1);
        rd(1'b1, v); chk(v == 2, "R10 first slot fetched", v, 2);
        expv[1] = 0;
        fetch('h02, r); chk(r == 6, "R10 second slot not cleared", r, 6);
        expv[2] = 0;
    endtask

    task automatic t_datawr();
        logic [31:0] v;
        int r;
        pulse(6, 2);
        fetch('h06, r);
        expv[6] = 0;
        pulse(7, 3);
        wr(1'b1, 32'h8000_0007);
        rd(1'b0, v); chk(v == 32'h6, "R12 no fetch from data write", v, 6);
        rd(1'b1, v); chk(v == 2, "R12 data word unchanged", v, 2);
        fetch('h07, r); chk(r == 3, "R12 counter intact", r, 3);
        expv[7] = 0;
    endtask

    task automatic t_sat();
        int r;
        pulse(20, MAXV + 45);
        fetch('h14, r); chk(r == MAXV, "R7 saturates at all ones", r, MAXV);
        expv[20] = 0;
        fetch('h14, r); chk(r == 0, "R7 cleared after saturated read", r, 0);
    endtask

    initial begin
        for (int i = 0; i < NS; i++) expv[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_hold();
        t_sparse();
        t_indep();
        t_invalid();
        t_collide();
        t_busy();
        t_datawr();
        t_sat();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule